// File: doc/BRIEF.md
# Two-Window I/O Register Decoder

This block sits between a host's 8-bit data, 16-bit address I/O bus and an expansion card that holds two peripherals. It compares every address bit and answers in two small windows. The two-address window at 0xFE80..0xFE81 is passed through to an external command/data device. The block raises a chip select, a data/command selector and per-direction strobes for that device, and returns the device's read data to the host. The eight-address window at 0xFEB0..0xFEB7 is a local register bank laid out like a common serial controller. This block holds the divisor latch, the interrupt-enable, line-control, modem-control and scratch registers. It turns accesses to the buffer and FIFO-control offsets into one-cycle strobes for the serial core, and reads the core's receive byte, identification, line-status and modem-status values back through its read multiplexer.

Bit 7 of the line-control register is a bank selector, held as a two-state machine. The state BANK_NORMAL maps offset 0 to the receive/transmit buffer and offset 1 to interrupt enable. The state BANK_DIVISOR maps those two offsets to the low and high divisor bytes. There are two transitions. A line-control write with bit 7 set moves the machine to BANK_DIVISOR ("open divisor"). A line-control write with bit 7 clear moves it to BANK_NORMAL ("close divisor"). Reset forces BANK_NORMAL. Reads are combinational in the same cycle as `bus_rd`. Writes take effect at the clock edge where `bus_wr` is high. Transmit data and external write data are taken directly from `bus_wdata`.

Top module: `io_window_decoder`

## Requirements
- R1: With address 0xFE80 and a strobe, `ext_cs` is 1 and `ext_cmd` is 0. `ext_wr` and `ext_rd` follow `bus_wr` and `bus_rd`. A read returns `ext_rdata` with `bus_rdata_en` high.
- R2: With address 0xFE81 and a strobe, the behaviour is the same as R1 except that `ext_cmd` is 1. This selects the command port on write and the status port on read.
- R3: For any address other than 0xFE80, 0xFE81 and 0xFEB0..0xFEB7, the block raises no chip select, strobe or `bus_rdata_en`, and a write changes no register.
- R4: The bank state is bit 7 of the line-control register at offset 3. A write to offset 3 sets the state from the value of bit 7 (1 gives BANK_DIVISOR). A read of offset 3 returns all 8 written bits.
- R5: In BANK_NORMAL, a write to offset 0 pulses `tx_push` for that cycle. A read of offset 0 returns `core_rx_data` and pulses `rx_pop`.
- R6: In BANK_NORMAL, offset 1 is the interrupt-enable register. It is read/write and is visible on `int_enable`.
- R7: In BANK_DIVISOR, offsets 0 and 1 read and write the low and high divisor bytes, visible on `divisor[7:0]` and `divisor[15:8]`. These accesses produce no `tx_push` or `rx_pop` and leave the interrupt-enable register unchanged.
- R8: Offsets 2 to 6 behave the same in both bank states. Offset 2 reads `core_iir`, and a write to it pulses `fcr_write`. Offset 4 is the read/write modem-control register. Offset 5 reads `core_lsr`. Offset 6 reads `core_msr`.
- R9: Offset 7 is a scratch register with no side effects. Writing 0x55 reads back 0x55.
- R10: The active-high synchronous reset clears the divisor, interrupt-enable, line-control, modem-control and scratch registers to 0x00 and sets the bank state to BANK_NORMAL.
- R11: When no read selects a register, `bus_rdata_en` is 0 and `bus_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | Host I/O address |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data, 0 when not driven |
| bus_rdata_en | output | 1 | The block is driving read data |
| ext_cs | output | 1 | External device chip select |
| ext_cmd | output | 1 | 1 selects the command/status port, 0 the data port |
| ext_wr | output | 1 | External device write strobe |
| ext_rd | output | 1 | External device read strobe |
| ext_rdata | input | 8 | External device read data |
| core_rx_data | input | 8 | Receive byte from the serial core |
| core_iir | input | 8 | Interrupt identification from the serial core |
| core_lsr | input | 8 | Line status from the serial core |
| core_msr | input | 8 | Modem status from the serial core |
| tx_push | output | 1 | Transmit buffer write strobe |
| rx_pop | output | 1 | Receive buffer read strobe |
| fcr_write | output | 1 | FIFO-control write strobe |
| divisor | output | 16 | Divisor latch {high, low} |
| line_ctrl | output | 8 | Line-control register |
| modem_ctrl | output | 8 | Modem-control register |
| int_enable | output | 8 | Interrupt-enable register |

## Verification
Directed accesses to the two passthrough addresses tell the data port from the command port, and tell writes from reads. Near-miss addresses differ from a valid one in a single high bit, or lie just past either end of a window. They show whether every address bit is compared, and a read of the scratch register afterwards shows that no stray write landed. Offsets 0 and 1 are accessed in both bank states, with the same stimulus before and after a line-control toggle. This separates divisor storage from the buffer strobes and the interrupt-enable register. A long pseudo-random mix of addresses, strobes and data, compared every cycle against a behavioural model, covers the interleavings that the directed cases miss.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;
    typedef enum logic {
        BANK_NORMAL  = 1'b0,
        BANK_DIVISOR = 1'b1
    } bank_e;

    localparam int OFS_W = 3;
    localparam logic [OFS_W-1:0] OFS_BUF   = 3'd0;
    localparam logic [OFS_W-1:0] OFS_IEN   = 3'd1;
    localparam logic [OFS_W-1:0] OFS_IDENT = 3'd2;
    localparam logic [OFS_W-1:0] OFS_LINE  = 3'd3;
    localparam logic [OFS_W-1:0] OFS_MODEM = 3'd4;
    localparam logic [OFS_W-1:0] OFS_LSTAT = 3'd5;
    localparam logic [OFS_W-1:0] OFS_MSTAT = 3'd6;
    localparam logic [OFS_W-1:0] OFS_SCR   = 3'd7;
endpackage

// File: rtl/win_decode.sv
module win_decode
    import io_dec_pkg::*;
#(
    parameter int          AW        = 16,
    parameter logic [AW-1:0] EXT_BASE  = 16'hFE80,
    parameter logic [AW-1:0] BANK_BASE = 16'hFEB0
) (
    input  logic [AW-1:0]    addr,
    output logic             ext_hit,
    output logic             ext_port,
    output logic             bank_hit,
    output logic [OFS_W-1:0] bank_ofs
);
    localparam int EXT_SPAN_W = 1;

    always_comb begin
        ext_hit  = (addr[AW-1:EXT_SPAN_W] == EXT_BASE[AW-1:EXT_SPAN_W]);
        ext_port = addr[0];
        bank_hit = (addr[AW-1:OFS_W] == BANK_BASE[AW-1:OFS_W]);
        bank_ofs = addr[OFS_W-1:0];
    end
endmodule

// File: rtl/reg_bank.sv
module reg_bank
    import io_dec_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [OFS_W-1:0] ofs,
    input  logic [DW-1:0]    wdata,
    output bank_e            bank,
    output logic [DW-1:0]    dll,
    output logic [DW-1:0]    dlm,
    output logic [DW-1:0]    ier,
    output logic [DW-1:0]    lcr,
    output logic [DW-1:0]    mcr,
    output logic [DW-1:0]    scr
);
    bank_e           bank_q, bank_d;
    logic [DW-2:0]   lcr_low;

    // state register
    always_ff @(posedge clk) begin
        if (rst) bank_q <= BANK_NORMAL;
        else     bank_q <= bank_d;
    end

    // next state: open/close divisor on line-control writes
    always_comb begin
        bank_d = bank_q;
        if (wr && ofs == OFS_LINE) begin
            unique case (wdata[DW-1])
                1'b1: bank_d = BANK_DIVISOR;
                1'b0: bank_d = BANK_NORMAL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dll <= '0; dlm <= '0; ier <= '0;
            lcr_low <= '0; mcr <= '0; scr <= '0;
        end else if (wr) begin
            case (ofs)
                OFS_BUF:   if (bank_q == BANK_DIVISOR) dll <= wdata;
                OFS_IEN:   if (bank_q == BANK_DIVISOR) dlm <= wdata;
                           else ier <= wdata;
                OFS_LINE:  lcr_low <= wdata[DW-2:0];
                OFS_MODEM: mcr <= wdata;
                OFS_SCR:   scr <= wdata;
                default: ;
            endcase
        end
    end

    assign bank = bank_q;
    assign lcr  = {bank_q == BANK_DIVISOR, lcr_low};

    assert_scr_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !(wr && ofs == OFS_SCR) |=> $stable(scr));
    assert_div_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (bank_q == BANK_NORMAL) |=> ($stable(dll) && $stable(dlm)));
    assert_ier_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (bank_q == BANK_DIVISOR) |=> $stable(ier));
endmodule

// File: rtl/read_mux.sv
module read_mux
    import io_dec_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             rd,
    input  logic             wr,
    input  logic             ext_hit,
    input  logic             bank_hit,
    input  logic [OFS_W-1:0] ofs,
    input  bank_e            bank,
    input  logic [DW-1:0]    ext_rdata,
    input  logic [DW-1:0]    rx_data,
    input  logic [DW-1:0]    iir,
    input  logic [DW-1:0]    lsr,
    input  logic [DW-1:0]    msr,
    input  logic [DW-1:0]    dll,
    input  logic [DW-1:0]    dlm,
    input  logic [DW-1:0]    ier,
    input  logic [DW-1:0]    lcr,
    input  logic [DW-1:0]    mcr,
    input  logic [DW-1:0]    scr,
    output logic [DW-1:0]    rdata,
    output logic             rdata_en,
    output logic             tx_push,
    output logic             rx_pop,
    output logic             fcr_write
);
    logic [DW-1:0] bank_val;

    always_comb begin
        bank_val = '0;
        unique case (ofs)
            OFS_BUF:   bank_val = (bank == BANK_DIVISOR) ? dll : rx_data;
            OFS_IEN:   bank_val = (bank == BANK_DIVISOR) ? dlm : ier;
            OFS_IDENT: bank_val = iir;
            OFS_LINE:  bank_val = lcr;
            OFS_MODEM: bank_val = mcr;
            OFS_LSTAT: bank_val = lsr;
            OFS_MSTAT: bank_val = msr;
            OFS_SCR:   bank_val = scr;
        endcase
    end

    always_comb begin
        rdata_en  = rd && (ext_hit || bank_hit);
        rdata     = '0;
        if (rd && ext_hit)       rdata = ext_rdata;
        else if (rd && bank_hit) rdata = bank_val;
        tx_push   = wr && bank_hit && ofs == OFS_BUF && bank == BANK_NORMAL;
        rx_pop    = rd && bank_hit && ofs == OFS_BUF && bank == BANK_NORMAL;
        fcr_write = wr && bank_hit && ofs == OFS_IDENT;
    end
endmodule

// File: rtl/io_window_decoder.sv
module io_window_decoder
    import io_dec_pkg::*;
#(
    parameter int            AW        = 16,
    parameter int            DW        = 8,
    parameter logic [AW-1:0] EXT_BASE  = 16'hFE80,
    parameter logic [AW-1:0] BANK_BASE = 16'hFEB0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            bus_rdata_en,
    output logic            ext_cs,
    output logic            ext_cmd,
    output logic            ext_wr,
    output logic            ext_rd,
    input  logic [DW-1:0]   ext_rdata,
    input  logic [DW-1:0]   core_rx_data,
    input  logic [DW-1:0]   core_iir,
    input  logic [DW-1:0]   core_lsr,
    input  logic [DW-1:0]   core_msr,
    output logic            tx_push,
    output logic            rx_pop,
    output logic            fcr_write,
    output logic [2*DW-1:0] divisor,
    output logic [DW-1:0]   line_ctrl,
    output logic [DW-1:0]   modem_ctrl,
    output logic [DW-1:0]   int_enable
);
    logic             ext_hit, ext_port, bank_hit;
    logic [OFS_W-1:0] ofs;
    bank_e            bank;
    logic [DW-1:0]    dll, dlm, ier, lcr, mcr, scr;

    win_decode #(.AW(AW), .EXT_BASE(EXT_BASE), .BANK_BASE(BANK_BASE)) u_dec (
        .addr(bus_addr), .ext_hit(ext_hit), .ext_port(ext_port),
        .bank_hit(bank_hit), .bank_ofs(ofs)
    );

    reg_bank #(.DW(DW)) u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr && bank_hit), .ofs(ofs),
        .wdata(bus_wdata), .bank(bank), .dll(dll), .dlm(dlm), .ier(ier),
        .lcr(lcr), .mcr(mcr), .scr(scr)
    );

    read_mux #(.DW(DW)) u_mux (
        .rd(bus_rd), .wr(bus_wr), .ext_hit(ext_hit), .bank_hit(bank_hit),
        .ofs(ofs), .bank(bank), .ext_rdata(ext_rdata), .rx_data(core_rx_data),
        .iir(core_iir), .lsr(core_lsr), .msr(core_msr), .dll(dll), .dlm(dlm),
        .ier(ier), .lcr(lcr), .mcr(mcr), .scr(scr), .rdata(bus_rdata),
        .rdata_en(bus_rdata_en), .tx_push(tx_push), .rx_pop(rx_pop),
        .fcr_write(fcr_write)
    );

    always_comb begin
        ext_cs  = ext_hit && (bus_wr || bus_rd);
        ext_cmd = ext_cs && ext_port;
        ext_wr  = ext_hit && bus_wr;
        ext_rd  = ext_hit && bus_rd;
    end

    assign divisor    = {dlm, dll};
    assign line_ctrl  = lcr;
    assign modem_ctrl = mcr;
    assign int_enable = ier;

    assert_cs_window_R3: assert property (@(posedge clk) disable iff (rst)
        ext_cs |-> (bus_addr[AW-1:1] == EXT_BASE[AW-1:1]));
    assert_bank_follows_lcr_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bank_hit && ofs == OFS_LINE) |=> (line_ctrl[DW-1] == $past(bus_wdata[DW-1])));
    assert_no_strobe_divisor_R7: assert property (@(posedge clk) disable iff (rst)
        line_ctrl[DW-1] |-> (!tx_push && !rx_pop));
    assert_idle_bus_R11: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (!bus_rdata_en && bus_rdata == '0));
    assert_one_window_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ext_cs, tx_push || rx_pop || fcr_write}));
endmodule

// File: tb/sim_io_window_decoder.sv
`timescale 1ns/1ps
module sim_io_window_decoder;
    logic        clk = 0;
    logic        rst = 1;
    logic [15:0] bus_addr = 0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [7:0]  bus_wdata = 0;
    logic [7:0]  bus_rdata;
    logic        bus_rdata_en, ext_cs, ext_cmd, ext_wr, ext_rd;
    logic [7:0]  ext_rdata = 8'h9E, core_rx_data = 8'hA5, core_iir = 8'hC1;
    logic [7:0]  core_lsr = 8'h60, core_msr = 8'h3B;
    logic        tx_push, rx_pop, fcr_write;
    logic [15:0] divisor;
    logic [7:0]  line_ctrl, modem_ctrl, int_enable;

    int n_cmp = 0, n_bad = 0, cycles = 0;
    bit done = 0;

    // behavioural model state
    int m_dll, m_dlm, m_ier, m_lcr, m_mcr, m_scr;

    always #2.5 clk = ~clk;

    io_window_decoder u0 (.*);

    task automatic cmp(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check(string tag);
        int a, ofs, e_rdata, e_en, e_cs, e_cmd, e_wr, e_rd, e_tx, e_pop, e_fcr;
        bit dlab;
        a = bus_addr; dlab = m_lcr[7];
        e_rdata = 0; e_en = 0; e_cs = 0; e_cmd = 0; e_wr = 0; e_rd = 0;
        e_tx = 0; e_pop = 0; e_fcr = 0;
        if (a == 'hFE80 || a == 'hFE81) begin
            e_cs = bus_wr | bus_rd; e_cmd = e_cs & (a == 'hFE81);
            e_wr = bus_wr; e_rd = bus_rd; e_en = bus_rd;
            if (bus_rd) e_rdata = ext_rdata;
        end else if (a >= 'hFEB0 && a <= 'hFEB7) begin
            ofs = a - 'hFEB0; e_en = bus_rd;
            case (ofs)
                0: if (dlab) e_rdata = m_dll;
                   else begin e_rdata = core_rx_data; e_pop = bus_rd; e_tx = bus_wr; end
                1: e_rdata = dlab ? m_dlm : m_ier;
                2: begin e_rdata = core_iir; e_fcr = bus_wr; end
                3: e_rdata = m_lcr;
                4: e_rdata = m_mcr;
                5: e_rdata = core_lsr;
                6: e_rdata = core_msr;
                default: e_rdata = m_scr;
            endcase
            if (!bus_rd) e_rdata = 0;
        end
        cmp(tag, "bus_rdata", bus_rdata, e_rdata);
        cmp(tag, "bus_rdata_en", bus_rdata_en, e_en);
        cmp(tag, "ext_cs", ext_cs, e_cs);
        cmp(tag, "ext_cmd", ext_cmd, e_cmd);
        cmp(tag, "ext_wr", ext_wr, e_wr);
        cmp(tag, "ext_rd", ext_rd, e_rd);
        cmp(tag, "tx_push", tx_push, e_tx);
        cmp(tag, "rx_pop", rx_pop, e_pop);
        cmp(tag, "fcr_write", fcr_write, e_fcr);
        cmp(tag, "divisor", divisor, m_dlm * 256 + m_dll);
        cmp(tag, "line_ctrl", line_ctrl, m_lcr);
        cmp(tag, "modem_ctrl", modem_ctrl, m_mcr);
        cmp(tag, "int_enable", int_enable, m_ier);
    endtask

    task automatic model_edge();
        int a;
        a = bus_addr;
        if (rst) begin
            m_dll = 0; m_dlm = 0; m_ier = 0; m_lcr = 0; m_mcr = 0; m_scr = 0;
        end else if (bus_wr && a >= 'hFEB0 && a <= 'hFEB7) begin
            case (a - 'hFEB0)
                0: if (m_lcr[7]) m_dll = bus_wdata;
                1: if (m_lcr[7]) m_dlm = bus_wdata; else m_ier = bus_wdata;
                3: m_lcr = bus_wdata;
                4: m_mcr = bus_wdata;
                7: m_scr = bus_wdata;
                default: ;
            endcase
        end
    endtask

    // one bus cycle: drive at negedge, compare before posedge, advance model
    task automatic acc(string tag, int a, bit w, bit r, int d);
        bus_addr = a[15:0]; bus_wr = w; bus_rd = r; bus_wdata = d[7:0];
        #1;
        check(tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            done = 1; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 200000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int s;
        int miss[8];
        int pool[14];
        miss = '{'hFE82, 'hFE7F, 'hFEB8, 'hFEAF, 'h7EB7, 'hFFB7, 'hFE37, 'hDE80};
        pool = '{'hFE80, 'hFE81, 'hFEB0, 'hFEB1, 'hFEB2, 'hFEB3, 'hFEB4,
                 'hFEB5, 'hFEB6, 'hFEB7, 'hFE82, 'hFEB8, 'h7EB3, 'hFEA0};
        m_dll = 0; m_dlm = 0; m_ier = 0; m_lcr = 0; m_mcr = 0; m_scr = 0;
        @(posedge clk); @(negedge clk);
        // R10: reset state while reset is held
        acc("R10", 'hFEB3, 1, 0, 'hFF);
        acc("R10", 'h0000, 0, 0, 0);
        rst = 0;
        // R11: idle
        acc("R11", 'hFEB7, 0, 0, 0);
        acc("R11", 'h1234, 0, 0, 0);
        // R1 / R2 passthrough
        acc("R1", 'hFE80, 1, 0, 'h06);
        acc("R1", 'hFE80, 0, 1, 0);
        acc("R2", 'hFE81, 1, 0, 'h06);
        ext_rdata = 8'h51;
        acc("R2", 'hFE81, 0, 1, 0);
        acc("R2", 'hFE81, 0, 0, 0);
        // R9 scratch
        acc("R9", 'hFEB7, 1, 0, 'h55);
        acc("R9", 'hFEB7, 0, 1, 0);
        // R3 near misses: write then read, then scratch must still be 0x55
        foreach (miss[i]) begin
            acc("R3", miss[i], 1, 0, 'hAA);
            acc("R3", miss[i], 0, 1, 0);
        end
        acc("R3", 'hFEB7, 0, 1, 0);
        // R5 / R6 normal bank
        acc("R5", 'hFEB0, 1, 0, 'h41);
        acc("R5", 'hFEB0, 0, 1, 0);
        acc("R6", 'hFEB1, 1, 0, 'h0F);
        acc("R6", 'hFEB1, 0, 1, 0);
        // R4 open divisor
        acc("R4", 'hFEB3, 1, 0, 'h83);
        acc("R4", 'hFEB3, 0, 1, 0);
        // R7 divisor access
        acc("R7", 'hFEB0, 1, 0, 'h0C);
        acc("R7", 'hFEB1, 1, 0, 'h02);
        acc("R7", 'hFEB0, 0, 1, 0);
        acc("R7", 'hFEB1, 0, 1, 0);
        // R8 fixed offsets in divisor bank
        acc("R8", 'hFEB2, 1, 0, 'hC7);
        acc("R8", 'hFEB2, 0, 1, 0);
        acc("R8", 'hFEB4, 1, 0, 'h0C);
        acc("R8", 'hFEB4, 0, 1, 0);
        acc("R8", 'hFEB5, 0, 1, 0);
        acc("R8", 'hFEB6, 0, 1, 0);
        // R4 close divisor, values retained
        acc("R4", 'hFEB3, 1, 0, 'h03);
        acc("R6", 'hFEB1, 0, 1, 0);
        acc("R8", 'hFEB2, 0, 1, 0);
        core_lsr = 8'h21; core_msr = 8'h84;
        acc("R8", 'hFEB5, 0, 1, 0);
        acc("R8", 'hFEB6, 0, 1, 0);
        // mixed pseudo-random traffic (all requirements, mainly R3/R4/R8)
        s = 32'h1ACE;
        for (int k = 0; k < 2000; k++) begin
            int idx, op;
            s = s * 1103515245 + 12345;
            idx = (s >>> 8) & 32'hFFFF;
            idx = idx % 14;
            op = (s >>> 4) & 3;
            core_rx_data = s[23:16]; ext_rdata = s[31:24];
            acc("R3", pool[idx], op == 1, op == 2, s[27:20]);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule